// File: doc/BRIEF.md
# Descriptor-Driven CRC Memory Scanner

This block is a small DMA engine that computes a CRC checksum over a region of memory. Software does not program the transfer through control registers. It builds a small descriptor in memory and writes the descriptor's address into a pointer register. It then turns on the CRC function and, as a second step, arms the DMA. From then on the block reads the start address and a control word from the descriptor. It streams the requested number of units (byte, halfword or word) from memory and folds each unit into a running CRC.

When the last unit has been absorbed, the engine writes the final checksum back into the descriptor's result slot. It then raises a sticky completion flag and, if the control word asked for it, an interrupt. Software can watch the checksum grow through a status register while the scan runs. The memory side is a single-outstanding request/ready master. The register side is a plain write strobe with a combinational read.

Top module: `crc_scan_dma`

## Requirements
- R1: Registers are selected by `reg_addr`: 0 descriptor pointer (read/write), 1 mode (bit 0 = CRC enable), 2 DMA arm (bit 0), 3 running CRC (read only), 4 flags (bit 0 = done, bit 1 = interrupt pending). After reset every register reads 0, and `mem_req` and `irq` are low.
- R2: Writing 1 to the DMA arm bit while CRC enable is 0 is ignored: the arm bit stays 0 and no memory request is issued. While the arm bit is 0, `mem_req` stays low.
- R3: An armed scan first reads the word at the pointer, then the word at pointer+4, both with `mem_size`=2. It never accesses pointer+8 or pointer+12.
- R4: In the control word, bits [15:0] give the unit count, bits [25:24] give the width (0 byte, 1 halfword, 2 word, 3 treated as word), and bit 27 enables the completion interrupt.
- R5: Data reads number exactly the unit count. Unit k is read at start+k·step, where step is 1, 2 or 4 for the width, and `mem_size` carries the width code.
- R6: The CRC uses the reflected polynomial 0xEDB88320 with seed 0xFFFFFFFF and no final inversion. Each unit is taken from the low bits of `mem_rdata`, least significant bit first, and the remaining bits are ignored.
- R7: The running CRC register shows the checksum including unit k from the cycle after unit k's read handshake.
- R8: A unit count of 0 issues no data reads and writes the seed value 0xFFFFFFFF as the result.
- R9: The final CRC is written as one word to pointer+16, which is the only write the block ever makes. Afterwards the done flag reads 1 and the DMA arm bit reads 0.
- R10: `irq` rises at completion only if the control word's interrupt bit was set. Writing 1 to flags bit 1 clears it, and writing 1 to flags bit 0 clears done without touching `irq`.
- R11: While `mem_req` is high and `mem_ready` is low, `mem_req`, `mem_addr` and `mem_we` hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register index |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational) |
| mem_req | output | 1 | Memory request |
| mem_we | output | 1 | Memory request is a write |
| mem_addr | output | 32 | Memory byte address |
| mem_size | output | 2 | Access size code (0 byte, 1 halfword, 2 word) |
| mem_wdata | output | 32 | Memory write data |
| mem_ready | input | 1 | Memory completes the request this cycle |
| mem_rdata | input | 32 | Read data, valid with `mem_ready` |
| irq | output | 1 | Completion interrupt |

## Verification
The assertions assume three things about the environment:
- The scanned region never overlaps the descriptor's reserved words or its result slot.
- The descriptor pointer is not rewritten while a scan is in flight.
- Read data is valid in the same cycle that `mem_ready` is high.

The stimulus keeps to these assumptions. It places every descriptor in a high memory window, well away from the data window it scans. It changes the pointer only between scans. Its memory model answers either at once or after one stall cycle, and drives read data together with ready.

// File: rtl/crc_scan_pkg.sv
package crc_scan_pkg;

    localparam int ADDR_W = 32;
    localparam int DATA_W = 32;
    localparam int CNT_W  = 16;
    localparam int RIDX_W = 3;

    localparam logic [DATA_W-1:0] CRC_POLY = 32'hEDB88320;
    localparam logic [DATA_W-1:0] CRC_SEED = 32'hFFFFFFFF;

    localparam logic [ADDR_W-1:0] OFS_START  = 32'd0;
    localparam logic [ADDR_W-1:0] OFS_CTRL   = 32'd4;
    localparam logic [ADDR_W-1:0] OFS_RESULT = 32'd16;

    localparam logic [RIDX_W-1:0] RIDX_PTR   = 3'd0;
    localparam logic [RIDX_W-1:0] RIDX_MODE  = 3'd1;
    localparam logic [RIDX_W-1:0] RIDX_ARM   = 3'd2;
    localparam logic [RIDX_W-1:0] RIDX_CRC   = 3'd3;
    localparam logic [RIDX_W-1:0] RIDX_FLAGS = 3'd4;

    typedef enum logic [2:0] {
        ST_IDLE, ST_FETCH_ADDR, ST_FETCH_CTRL, ST_READ_DATA, ST_WRITE_RESULT, ST_DONE
    } scan_state_e;

    typedef enum logic [1:0] {
        UNIT_BYTE = 2'd0, UNIT_HALF = 2'd1, UNIT_WORD = 2'd2, UNIT_RSVD = 2'd3
    } unit_width_e;

    typedef struct packed {
        logic              irq_en;
        unit_width_e       width;
        logic [CNT_W-1:0]  count;
    } xfer_ctrl_t;

    function automatic xfer_ctrl_t decode_ctrl(input logic [DATA_W-1:0] w);
        xfer_ctrl_t c;
        c.count  = w[CNT_W-1:0];
        c.width  = (w[25:24] == 2'd3) ? UNIT_WORD : unit_width_e'(w[25:24]);
        c.irq_en = w[27];
        return c;
    endfunction

    function automatic logic [ADDR_W-1:0] unit_step(input unit_width_e w);
        case (w)
            UNIT_BYTE: return 32'd1;
            UNIT_HALF: return 32'd2;
            default:   return 32'd4;
        endcase
    endfunction

    function automatic logic [5:0] unit_bits(input unit_width_e w);
        case (w)
            UNIT_BYTE: return 6'd8;
            UNIT_HALF: return 6'd16;
            default:   return 6'd32;
        endcase
    endfunction

    function automatic logic [DATA_W-1:0] crc_feed(input logic [DATA_W-1:0] crc,
                                                   input logic [DATA_W-1:0] data,
                                                   input logic [5:0]        nbits);
        logic [DATA_W-1:0] c;
        c = crc;
        for (int i = 0; i < DATA_W; i++) begin
            if (i < int'(nbits)) begin
                if (c[0] ^ data[i]) c = (c >> 1) ^ CRC_POLY;
                else                c = c >> 1;
            end
        end
        return c;
    endfunction

endpackage

// File: rtl/crc_scan_regs.sv
module crc_scan_regs
    import crc_scan_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              reg_we,
    input  logic [RIDX_W-1:0] reg_addr,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    input  logic [DATA_W-1:0] crc_value,
    input  logic              done_pulse,
    input  logic              irq_set,
    output logic [ADDR_W-1:0] desc_ptr,
    output logic              crc_en,
    output logic              dma_en,
    output logic              done_flag,
    output logic              irq_pend
);
    logic wr_ptr, wr_mode, wr_arm, wr_flags;

    always_comb begin
        wr_ptr   = reg_we && (reg_addr == RIDX_PTR);
        wr_mode  = reg_we && (reg_addr == RIDX_MODE);
        wr_arm   = reg_we && (reg_addr == RIDX_ARM);
        wr_flags = reg_we && (reg_addr == RIDX_FLAGS);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            desc_ptr  <= '0;
            crc_en    <= 1'b0;
            dma_en    <= 1'b0;
            done_flag <= 1'b0;
            irq_pend  <= 1'b0;
        end else begin
            if (wr_ptr)  desc_ptr <= reg_wdata;
            if (wr_mode) crc_en   <= reg_wdata[0];
            if (done_pulse)                           dma_en <= 1'b0;
            else if (wr_arm && reg_wdata[0] && crc_en) dma_en <= 1'b1;
            if (done_pulse)                    done_flag <= 1'b1;
            else if (wr_flags && reg_wdata[0]) done_flag <= 1'b0;
            if (irq_set)                       irq_pend <= 1'b1;
            else if (wr_flags && reg_wdata[1]) irq_pend <= 1'b0;
        end
    end

    always_comb begin
        case (reg_addr)
            RIDX_PTR:   reg_rdata = desc_ptr;
            RIDX_MODE:  reg_rdata = {31'd0, crc_en};
            RIDX_ARM:   reg_rdata = {31'd0, dma_en};
            RIDX_CRC:   reg_rdata = crc_value;
            RIDX_FLAGS: reg_rdata = {30'd0, irq_pend, done_flag};
            default:    reg_rdata = '0;
        endcase
    end
endmodule

// File: rtl/crc_scan_crc.sv
module crc_scan_crc
    import crc_scan_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              seed,
    input  logic              feed,
    input  logic [DATA_W-1:0] unit_data,
    input  logic [5:0]        nbits,
    output logic [DATA_W-1:0] crc
);
    always_ff @(posedge clk) begin
        if (rst)       crc <= '0;
        else if (seed) crc <= CRC_SEED;
        else if (feed) crc <= crc_feed(crc, unit_data, nbits);
    end
endmodule

// File: rtl/crc_scan_fsm.sv
module crc_scan_fsm
    import crc_scan_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              armed,
    input  logic [ADDR_W-1:0] desc_ptr,
    input  logic [DATA_W-1:0] crc_value,
    output logic              mem_req,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [1:0]        mem_size,
    output logic [DATA_W-1:0] mem_wdata,
    input  logic              mem_ready,
    input  logic [DATA_W-1:0] mem_rdata,
    output logic              crc_seed,
    output logic              crc_load,
    output logic [5:0]        crc_nbits,
    output logic              done_pulse,
    output logic              irq_set
);
    scan_state_e      state;
    xfer_ctrl_t       ctrl;
    logic [ADDR_W-1:0] cur_addr;
    logic [CNT_W-1:0]  remaining;
    logic              hs;

    always_comb begin
        mem_req   = (state == ST_FETCH_ADDR) || (state == ST_FETCH_CTRL) ||
                    (state == ST_READ_DATA)  || (state == ST_WRITE_RESULT);
        mem_we    = (state == ST_WRITE_RESULT);
        mem_wdata = crc_value;
        mem_size  = (state == ST_READ_DATA) ? ctrl.width : UNIT_WORD;
        case (state)
            ST_FETCH_ADDR:   mem_addr = desc_ptr + OFS_START;
            ST_FETCH_CTRL:   mem_addr = desc_ptr + OFS_CTRL;
            ST_READ_DATA:    mem_addr = cur_addr;
            ST_WRITE_RESULT: mem_addr = desc_ptr + OFS_RESULT;
            default:         mem_addr = '0;
        endcase
        hs         = mem_req && mem_ready;
        crc_seed   = (state == ST_IDLE) && armed;
        crc_load   = (state == ST_READ_DATA) && hs;
        crc_nbits  = unit_bits(ctrl.width);
        done_pulse = (state == ST_DONE);
        irq_set    = done_pulse && ctrl.irq_en;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state     <= ST_IDLE;
            ctrl      <= '0;
            cur_addr  <= '0;
            remaining <= '0;
        end else begin
            case (state)
                ST_IDLE: if (armed) state <= ST_FETCH_ADDR;
                ST_FETCH_ADDR: if (hs) begin
                    cur_addr <= mem_rdata;
                    state    <= ST_FETCH_CTRL;
                end
                ST_FETCH_CTRL: if (hs) begin
                    ctrl      <= decode_ctrl(mem_rdata);
                    remaining <= mem_rdata[CNT_W-1:0];
                    state     <= (mem_rdata[CNT_W-1:0] == '0) ? ST_WRITE_RESULT : ST_READ_DATA;
                end
                ST_READ_DATA: if (hs) begin
                    cur_addr  <= cur_addr + unit_step(ctrl.width);
                    remaining <= remaining - 1'b1;
                    if (remaining == 16'd1) state <= ST_WRITE_RESULT;
                end
                ST_WRITE_RESULT: if (hs) state <= ST_DONE;
                ST_DONE: state <= ST_IDLE;
                default: state <= ST_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/crc_scan_dma.sv
module crc_scan_dma
    import crc_scan_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              reg_we,
    input  logic [RIDX_W-1:0] reg_addr,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    output logic              mem_req,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [1:0]        mem_size,
    output logic [DATA_W-1:0] mem_wdata,
    input  logic              mem_ready,
    input  logic [DATA_W-1:0] mem_rdata,
    output logic              irq
);
    logic [ADDR_W-1:0] desc_ptr;
    logic [DATA_W-1:0] crc_value;
    logic              crc_en, dma_en, done_flag, irq_pend;
    logic              done_pulse, irq_set, crc_seed, crc_load;
    logic [5:0]        crc_nbits;

    crc_scan_regs u_regs (
        .clk(clk), .rst(rst), .reg_we(reg_we), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .crc_value(crc_value),
        .done_pulse(done_pulse), .irq_set(irq_set), .desc_ptr(desc_ptr),
        .crc_en(crc_en), .dma_en(dma_en), .done_flag(done_flag), .irq_pend(irq_pend)
    );

    crc_scan_fsm u_fsm (
        .clk(clk), .rst(rst), .armed(dma_en), .desc_ptr(desc_ptr),
        .crc_value(crc_value), .mem_req(mem_req), .mem_we(mem_we),
        .mem_addr(mem_addr), .mem_size(mem_size), .mem_wdata(mem_wdata),
        .mem_ready(mem_ready), .mem_rdata(mem_rdata), .crc_seed(crc_seed),
        .crc_load(crc_load), .crc_nbits(crc_nbits), .done_pulse(done_pulse),
        .irq_set(irq_set)
    );

    crc_scan_crc u_crc (
        .clk(clk), .rst(rst), .seed(crc_seed), .feed(crc_load),
        .unit_data(mem_rdata), .nbits(crc_nbits), .crc(crc_value)
    );

    assign irq = irq_pend;
endmodule

// File: rtl/crc_scan_dma_chk.sv
module crc_scan_dma_chk
    import crc_scan_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              mem_req,
    input logic              mem_we,
    input logic              mem_ready,
    input logic [ADDR_W-1:0] mem_addr,
    input logic [ADDR_W-1:0] desc_ptr,
    input logic              crc_en,
    input logic              dma_en,
    input logic              done_pulse,
    input logic              irq
);
    AST_REQ_HOLD: assert property (@(posedge clk) disable iff (rst)
        (mem_req && !mem_ready) |=> (mem_req && $stable(mem_addr) && $stable(mem_we))); // R11
    AST_NO_RESERVED: assert property (@(posedge clk) disable iff (rst)
        mem_req |-> (mem_addr != desc_ptr + 32'd8 && mem_addr != desc_ptr + 32'd12)); // R3
    AST_WRITE_SLOT_ONLY: assert property (@(posedge clk) disable iff (rst)
        (mem_req && mem_we) |-> (mem_addr == desc_ptr + OFS_RESULT)); // R9
    AST_ARM_NEEDS_CRC: assert property (@(posedge clk) disable iff (rst)
        $rose(dma_en) |-> crc_en); // R2
    AST_QUIET_UNARMED: assert property (@(posedge clk) disable iff (rst)
        !dma_en |-> !mem_req); // R2
    AST_IRQ_AT_DONE: assert property (@(posedge clk) disable iff (rst)
        $rose(irq) |-> $past(done_pulse)); // R10
endmodule

bind crc_scan_dma crc_scan_dma_chk u_chk (
    .clk(clk), .rst(rst), .mem_req(mem_req), .mem_we(mem_we), .mem_ready(mem_ready),
    .mem_addr(mem_addr), .desc_ptr(desc_ptr), .crc_en(crc_en), .dma_en(dma_en),
    .done_pulse(done_pulse), .irq(irq)
);

// File: tb/crc_scan_dma_test.sv
module crc_scan_dma_test;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        reg_we = 1'b0;
    logic [2:0]  reg_addr = 3'd0;
    logic [31:0] reg_wdata = 32'd0;
    logic [31:0] reg_rdata;
    logic        mem_req, mem_we, mem_ready;
    logic [31:0] mem_addr, mem_wdata, mem_rdata;
    logic [1:0]  mem_size;
    logic        irq;

    int checks = 0;
    int failures = 0;
    int cycles = 0;

    logic [7:0]  mem [0:1023];
    logic        stall_mode = 1'b0;
    logic        phase = 1'b0;

    logic [31:0] cur_ptr = 32'd0, exp_addr = 32'd0, model_crc = 32'd0;
    logic [1:0]  exp_size = 2'd0;
    int          rd_n = 0, data_n = 0, addr_err = 0, fetch_err = 0, rsvd_hits = 0, wr_n = 0;
    int          req_seen = 0;
    logic        status_pend = 1'b0;
    logic        scan_on = 1'b0;

    crc_scan_dma uut (
        .clk(clk), .rst(rst), .reg_we(reg_we), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .mem_req(mem_req),
        .mem_we(mem_we), .mem_addr(mem_addr), .mem_size(mem_size),
        .mem_wdata(mem_wdata), .mem_ready(mem_ready), .mem_rdata(mem_rdata), .irq(irq)
    );

    always #5 clk = ~clk;

    function automatic logic [31:0] rd_word(input logic [31:0] a);
        return {mem[(a + 32'd3) & 32'h3FF], mem[(a + 32'd2) & 32'h3FF],
                mem[(a + 32'd1) & 32'h3FF], mem[a & 32'h3FF]};
    endfunction

    function automatic logic [31:0] crc_byte(input logic [31:0] c, input logic [7:0] b);
        logic [31:0] r;
        r = c;
        for (int i = 0; i < 8; i++)
            r = (r >> 1) ^ (32'hEDB88320 & {32{r[0] ^ b[i]}});
        return r;
    endfunction

    assign mem_ready = mem_req && (!stall_mode || phase);
    assign mem_rdata = rd_word(mem_addr);

    task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // bench memory and bus monitor
    always @(posedge clk) begin
        cycles <= cycles + 1;
        phase  <= ~phase;
        if (mem_req) req_seen++;
        if (mem_req && (mem_addr == cur_ptr + 32'd8 || mem_addr == cur_ptr + 32'd12)) rsvd_hits++;
        if (mem_req && mem_ready && scan_on) begin
            if (mem_we) begin
                wr_n++;
                for (int b = 0; b < 4; b++) mem[(mem_addr + b) & 32'h3FF] = mem_wdata[8*b +: 8];
            end else begin
                if (rd_n == 0) begin
                    if (mem_addr != cur_ptr || mem_size != 2'd2) fetch_err++;
                end else if (rd_n == 1) begin
                    if (mem_addr != cur_ptr + 32'd4 || mem_size != 2'd2) fetch_err++;
                end else begin
                    if (mem_addr != exp_addr || mem_size != exp_size) addr_err++;
                    for (int b = 0; b < (1 << exp_size); b++)
                        model_crc = crc_byte(model_crc, mem[(exp_addr + b) & 32'h3FF]);
                    exp_addr = exp_addr + (32'd1 << exp_size);
                    data_n++;
                    status_pend = 1'b1;
                end
                rd_n++;
            end
        end
    end

    // R7: running CRC visible one cycle after each unit handshake
    always @(negedge clk) begin
        if (status_pend) begin
            status_pend = 1'b0;
            check(reg_rdata == model_crc, "R7 running crc", reg_rdata, model_crc);
        end
    end

    task automatic reg_write(input logic [2:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_addr = a; reg_wdata = d; reg_we = 1'b1;
        @(negedge clk);
        reg_we = 1'b0; reg_addr = 3'd3;
    endtask

    task automatic reg_read(input logic [2:0] a, output logic [31:0] d);
        @(negedge clk);
        reg_addr = a;
        #1 d = reg_rdata;
        reg_addr = 3'd3;
    endtask

    task automatic put_word(input logic [31:0] a, input logic [31:0] d);
        for (int b = 0; b < 4; b++) mem[(a + b) & 32'h3FF] = d[8*b +: 8];
    endtask

    task automatic run_scan(input logic [31:0] ptr, input logic [31:0] start,
                            input int count, input int width, input bit ie, input bit stall);
        logic [31:0] exp_crc, v;
        int t;
        put_word(ptr, start);
        put_word(ptr + 4, {4'd0, ie, 1'b0, 2'(width), 8'hA5, 16'(count)});
        put_word(ptr + 8, 32'h0BAD0BAD);
        put_word(ptr + 12, 32'h0BAD0BAD);
        put_word(ptr + 16, 32'hDEADBEEF);
        exp_crc = 32'hFFFFFFFF;
        for (int k = 0; k < count * (1 << width); k++)
            exp_crc = crc_byte(exp_crc, mem[(start + k) & 32'h3FF]);
        @(negedge clk);
        stall_mode = stall;
        cur_ptr = ptr; exp_addr = start; exp_size = 2'(width);
        model_crc = 32'hFFFFFFFF;
        rd_n = 0; data_n = 0; addr_err = 0; fetch_err = 0; rsvd_hits = 0; wr_n = 0;
        reg_write(3'd0, ptr);
        reg_write(3'd1, 32'd1);
        scan_on = 1'b1;
        reg_write(3'd2, 32'd1);
        t = 0;
        while (wr_n == 0 && t < 2000) begin @(negedge clk); t++; end
        check(t < 2000, "R9 completion timeout", 32'(t), 32'd0);
        repeat (3) @(negedge clk);
        scan_on = 1'b0;
        check(fetch_err == 0, "R3 descriptor fetch order", 32'(fetch_err), 0);
        check(rsvd_hits == 0, "R3 reserved slots untouched", 32'(rsvd_hits), 0);
        check(data_n == count, "R5 data read count (R8 for zero)", 32'(data_n), 32'(count));
        check(addr_err == 0, "R5 data address and size", 32'(addr_err), 0);
        check(wr_n == 1, "R9 single write", 32'(wr_n), 1);
        check(rd_word(ptr + 16) == exp_crc, "R6 result value (R4 control decode)", rd_word(ptr + 16), exp_crc);
        reg_read(3'd4, v);
        check(v[0] == 1'b1, "R9 done flag", v, 32'(ie) << 1 | 1);
        check(irq == ie, "R10 irq follows enable", 32'(irq), 32'(ie));
        reg_read(3'd2, v);
        check(v == 32'd0, "R9 arm self-clear", v, 0);
        reg_write(3'd4, 32'd1);
        check(irq == ie, "R10 clearing done keeps irq", 32'(irq), 32'(ie));
        reg_write(3'd4, 32'd2);
        reg_read(3'd4, v);
        check(v == 32'd0 && irq == 1'b0, "R10 W1C clears flags", v, 0);
    endtask

    initial begin
        logic [31:0] v;
        int cnts [4] = '{0, 1, 2, 5};
        for (int a = 0; a < 1024; a++) mem[a] = 8'((a * 37 + 11) ^ (a >> 3));
        repeat (3) @(negedge clk);
        rst = 1'b0;
        check(mem_req == 1'b0 && irq == 1'b0, "R1 reset outputs", {mem_req, irq}, 0);
        for (int r = 0; r < 5; r++) begin
            reg_read(3'(r), v);
            check(v == 32'd0, "R1 reset register", v, 0);
        end
        reg_write(3'd0, 32'h0000_0321);
        reg_read(3'd0, v);
        check(v == 32'h321, "R1 pointer readback", v, 32'h321);
        req_seen = 0;
        reg_write(3'd2, 32'd1);
        repeat (6) @(negedge clk);
        reg_read(3'd2, v);
        check(v == 32'd0 && req_seen == 0, "R2 arm ignored without crc enable", v | 32'(req_seen), 0);
        for (int w = 0; w < 3; w++)
            for (int c = 0; c < 4; c++)
                run_scan(32'h300 + 32'(c * 32), 32'h40 + 32'(w * 3 + c),
                         cnts[c], w, bit'((w + c) & 1), bit'(c & 1)); // R4 R5 R6 R8
        run_scan(32'h380, 32'h10, 7, 2, 1'b1, 1'b1);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        wait (cycles > 150000);
        failures++;
        checks++;
        $display("FAIL watchdog actual=%0d expected=<150000", cycles);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule